// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired control unit for a processor datapath that spends several clock cycles on each instruction. It holds a four-bit step register, looks at the six-bit opcode held in the datapath's instruction register, and drives the datapath's strobes and multiplexer selects. Every output is a function of the current step alone (Moore style).

Each instruction starts with a fetch step and a decode step. Decode then branches by opcode class into an address step (loads and stores), an ALU execute step, a branch-resolve step or a jump step. The address step branches again on load versus store. Loads take five cycles, stores and register-register ALU operations four, and branches and jumps three. An opcode outside the supported set returns to fetch straight after decode, and no write strobe is raised on the way.

Top module: `mcc_ctrl`

## Requirements
- R1: A synchronous reset, seen at a rising clock edge, puts the sequencer in the fetch step from the next cycle. This holds even in the middle of an instruction.
- R2: Fetch raises mem_rd_o, ir_load_o and pc_wr_o, with mem_addr_sel_o=0, alu_a_sel_o=0, alu_b_sel_o=01, alu_mode_o=00 and pc_src_o=00, and holds every other output at 0. The next step is always decode.
- R3: Decode drives alu_a_sel_o=0, alu_b_sel_o=11 and alu_mode_o=00, and holds every other output at 0.
- R4: After decode the next step depends on the opcode. Opcodes 100011 (load) and 101011 (store) go to the address step, 000000 (register ALU) to execute, 000100 (branch-equal) to branch resolve, and 000010 (jump) to jump.
- R5: The address step drives alu_a_sel_o=1, alu_b_sel_o=10 and alu_mode_o=00. From there, opcode 100011 goes to the load-read step, 101011 goes to the store step, and any other opcode goes to fetch.
- R6: The load-read step raises mem_rd_o with mem_addr_sel_o=1. The next step is load write-back, which raises rf_wr_o with rf_dst_sel_o=0 and rf_data_sel_o=1, then returns to fetch. A load takes 5 cycles.
- R7: The store step raises mem_wr_o with mem_addr_sel_o=1, then returns to fetch. A store takes 4 cycles.
- R8: The execute step drives alu_a_sel_o=1, alu_b_sel_o=00 and alu_mode_o=10. The next step is ALU write-back, which raises rf_wr_o with rf_dst_sel_o=1 and rf_data_sel_o=0, then returns to fetch. The instruction takes 4 cycles.
- R9: Branch resolve drives alu_a_sel_o=1, alu_b_sel_o=00, alu_mode_o=01, pc_wr_cond_o=1 and pc_src_o=01, then returns to fetch. The instruction takes 3 cycles.
- R10: The jump step raises pc_wr_o with pc_src_o=10, then returns to fetch. The instruction takes 3 cycles.
- R11: An opcode outside the five listed values, seen in decode, returns the sequencer to fetch after 2 cycles, and no write strobe is raised.
- R12: The opcode is ignored in every step except decode and the address step. Changing it in any other step leaves the sequence of outputs unchanged.
- R13: At most one of pc_wr_o, pc_wr_cond_o, mem_wr_o and rf_wr_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| op_i | input | 6 | Opcode field from the instruction register |
| pc_wr_o | output | 1 | Unconditional program-counter write |
| pc_wr_cond_o | output | 1 | Program-counter write qualified by ALU zero |
| mem_addr_sel_o | output | 1 | Memory address source: 0 = PC, 1 = ALU result register |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| ir_load_o | output | 1 | Instruction register load |
| rf_data_sel_o | output | 1 | Register write data: 0 = ALU result, 1 = memory data |
| pc_src_o | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_mode_o | output | 2 | ALU mode: 00 add, 01 subtract, 10 from function field |
| alu_b_sel_o | output | 2 | ALU B input: 00 reg B, 01 constant 4, 10 immediate, 11 shifted immediate |
| alu_a_sel_o | output | 1 | ALU A input: 0 = PC, 1 = reg A |
| rf_wr_o | output | 1 | Register file write strobe |
| rf_dst_sel_o | output | 1 | Destination register field: 0 = rt, 1 = rd |

## Verification
Each of the five supported opcodes is run through a full instruction. Comparing every output on every cycle tells the decode dispatch, the load/store split and the cycle count of each class apart. Two undefined opcodes are run: one all-ones, and one that differs from the load code in a single bit, which catches a partial opcode compare. A stray opcode is also presented at the address step. Other runs swap the opcode for a different legal one part-way through an instruction, to show that later steps do not sample it. A reset in the middle of a load shows that reset overrides the sequence.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int OP_W   = 6;
    localparam int STEP_W = 4;

    localparam logic [OP_W-1:0] OPC_ALU    = 6'b000000;
    localparam logic [OP_W-1:0] OPC_JUMP   = 6'b000010;
    localparam logic [OP_W-1:0] OPC_BRANCH = 6'b000100;
    localparam logic [OP_W-1:0] OPC_LOAD   = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STORE  = 6'b101011;

    typedef enum logic [STEP_W-1:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_ADDR   = 4'd2,
        ST_LDRD   = 4'd3,
        ST_LDWB   = 4'd4,
        ST_STWR   = 4'd5,
        ST_EXEC   = 4'd6,
        ST_ALUWB  = 4'd7,
        ST_BRCH   = 4'd8,
        ST_JUMP   = 4'd9
    } step_e;

    typedef enum logic [2:0] {
        CL_ALU,
        CL_LOAD,
        CL_STORE,
        CL_BRANCH,
        CL_JUMP,
        CL_BAD
    } opcls_e;

    typedef struct packed {
        logic       pc_wr;
        logic       pc_wr_cond;
        logic       mem_addr_sel;
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_load;
        logic       rf_data_sel;
        logic [1:0] pc_src;
        logic [1:0] alu_mode;
        logic [1:0] alu_b_sel;
        logic       alu_a_sel;
        logic       rf_wr;
        logic       rf_dst_sel;
    } ctrl_t;

    typedef struct packed {
        step_e step;
    } seq_t;

endpackage

// File: rtl/mcc_opclass.sv
module mcc_opclass
    import mcc_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output opcls_e          cls_o
);
    always_comb begin
        case (op_i)
            OPC_ALU:    cls_o = CL_ALU;
            OPC_LOAD:   cls_o = CL_LOAD;
            OPC_STORE:  cls_o = CL_STORE;
            OPC_BRANCH: cls_o = CL_BRANCH;
            OPC_JUMP:   cls_o = CL_JUMP;
            default:    cls_o = CL_BAD;
        endcase
    end
endmodule

// File: rtl/mcc_next.sv
module mcc_next
    import mcc_pkg::*;
(
    input  step_e  step_i,
    input  opcls_e cls_i,
    output step_e  step_o
);
    always_comb begin
        step_o = ST_FETCH;
        case (step_i)
            ST_FETCH: step_o = ST_DECODE;
            ST_DECODE: begin
                case (cls_i)
                    CL_LOAD, CL_STORE: step_o = ST_ADDR;
                    CL_ALU:            step_o = ST_EXEC;
                    CL_BRANCH:         step_o = ST_BRCH;
                    CL_JUMP:           step_o = ST_JUMP;
                    default:           step_o = ST_FETCH;
                endcase
            end
            ST_ADDR: begin
                case (cls_i)
                    CL_LOAD:  step_o = ST_LDRD;
                    CL_STORE: step_o = ST_STWR;
                    default:  step_o = ST_FETCH;
                endcase
            end
            ST_LDRD: step_o = ST_LDWB;
            ST_EXEC: step_o = ST_ALUWB;
            default: step_o = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mcc_outdec.sv
module mcc_outdec
    import mcc_pkg::*;
(
    input  step_e step_i,
    output ctrl_t ctrl_o
);
    always_comb begin
        ctrl_o = '0;
        case (step_i)
            ST_FETCH: begin
                ctrl_o.mem_rd    = 1'b1;
                ctrl_o.ir_load   = 1'b1;
                ctrl_o.pc_wr     = 1'b1;
                ctrl_o.alu_b_sel = 2'b01;
            end
            ST_DECODE: begin
                ctrl_o.alu_b_sel = 2'b11;
            end
            ST_ADDR: begin
                ctrl_o.alu_a_sel = 1'b1;
                ctrl_o.alu_b_sel = 2'b10;
            end
            ST_LDRD: begin
                ctrl_o.mem_rd       = 1'b1;
                ctrl_o.mem_addr_sel = 1'b1;
            end
            ST_LDWB: begin
                ctrl_o.rf_wr       = 1'b1;
                ctrl_o.rf_data_sel = 1'b1;
            end
            ST_STWR: begin
                ctrl_o.mem_wr       = 1'b1;
                ctrl_o.mem_addr_sel = 1'b1;
            end
            ST_EXEC: begin
                ctrl_o.alu_a_sel = 1'b1;
                ctrl_o.alu_mode  = 2'b10;
            end
            ST_ALUWB: begin
                ctrl_o.rf_wr      = 1'b1;
                ctrl_o.rf_dst_sel = 1'b1;
            end
            ST_BRCH: begin
                ctrl_o.alu_a_sel  = 1'b1;
                ctrl_o.alu_mode   = 2'b01;
                ctrl_o.pc_wr_cond = 1'b1;
                ctrl_o.pc_src     = 2'b01;
            end
            ST_JUMP: begin
                ctrl_o.pc_wr  = 1'b1;
                ctrl_o.pc_src = 2'b10;
            end
            default: ctrl_o = '0;
        endcase
    end
endmodule

// File: rtl/mcc_ctrl.sv
module mcc_ctrl
    import mcc_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [OP_W-1:0] op_i,
    output logic            pc_wr_o,
    output logic            pc_wr_cond_o,
    output logic            mem_addr_sel_o,
    output logic            mem_rd_o,
    output logic            mem_wr_o,
    output logic            ir_load_o,
    output logic            rf_data_sel_o,
    output logic [1:0]      pc_src_o,
    output logic [1:0]      alu_mode_o,
    output logic [1:0]      alu_b_sel_o,
    output logic            alu_a_sel_o,
    output logic            rf_wr_o,
    output logic            rf_dst_sel_o
);
    seq_t   state_d, state_q;
    opcls_e cls;
    step_e  step_nxt;
    ctrl_t  ctrl;
    logic [STEP_W-1:0] step_q_w;

    mcc_opclass u_cls (
        .op_i  (op_i),
        .cls_o (cls)
    );

    mcc_next u_next (
        .step_i (state_q.step),
        .cls_i  (cls),
        .step_o (step_nxt)
    );

    mcc_outdec u_out (
        .step_i (state_q.step),
        .ctrl_o (ctrl)
    );

    always_comb begin
        state_d      = state_q;
        state_d.step = step_nxt;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= '{step: ST_FETCH};
        end else begin
            state_q <= state_d;
        end
    end

    assign step_q_w       = state_q.step;
    assign pc_wr_o        = ctrl.pc_wr;
    assign pc_wr_cond_o   = ctrl.pc_wr_cond;
    assign mem_addr_sel_o = ctrl.mem_addr_sel;
    assign mem_rd_o       = ctrl.mem_rd;
    assign mem_wr_o       = ctrl.mem_wr;
    assign ir_load_o      = ctrl.ir_load;
    assign rf_data_sel_o  = ctrl.rf_data_sel;
    assign pc_src_o       = ctrl.pc_src;
    assign alu_mode_o     = ctrl.alu_mode;
    assign alu_b_sel_o    = ctrl.alu_b_sel;
    assign alu_a_sel_o    = ctrl.alu_a_sel;
    assign rf_wr_o        = ctrl.rf_wr;
    assign rf_dst_sel_o   = ctrl.rf_dst_sel;
endmodule

// File: rtl/mcc_ctrl_chk.sv
module mcc_ctrl_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic [5:0] op_i,
    input logic [3:0] step_i,
    input logic       pc_wr_i,
    input logic       pc_wr_cond_i,
    input logic       mem_addr_sel_i,
    input logic       mem_rd_i,
    input logic       mem_wr_i,
    input logic       ir_load_i,
    input logic       rf_data_sel_i,
    input logic       rf_wr_i,
    input logic       rf_dst_sel_i
);
    logic op_known;
    assign op_known = (op_i == 6'b000000) || (op_i == 6'b000010) ||
                      (op_i == 6'b000100) || (op_i == 6'b100011) ||
                      (op_i == 6'b101011);

    assert_reset_fetch_R1: assert property (@(posedge clk_i)
        rst_i |=> (step_i == 4'd0 && ir_load_i));

    assert_fetch_to_decode_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i == 4'd0) |=> (step_i == 4'd1));

    assert_decode_quiet_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i == 4'd1) |-> !(pc_wr_i || pc_wr_cond_i || mem_wr_i || rf_wr_i || mem_rd_i || ir_load_i));

    assert_branch_dispatch_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i == 4'd1 && op_i == 6'b000100) |=> pc_wr_cond_i);

    assert_load_chain_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (mem_rd_i && mem_addr_sel_i) |=> (rf_wr_i && rf_data_sel_i && !rf_dst_sel_i));

    assert_store_return_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        mem_wr_i |=> (step_i == 4'd0));

    assert_alu_writeback_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i == 4'd6) |=> (rf_wr_i && rf_dst_sel_i && !rf_data_sel_i));

    assert_bad_op_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i == 4'd1 && !op_known) |=> (step_i == 4'd0));

    assert_one_write_R13: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({pc_wr_i, pc_wr_cond_i, mem_wr_i, rf_wr_i}));
endmodule

bind mcc_ctrl mcc_ctrl_chk u_chk (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .op_i           (op_i),
    .step_i         (step_q_w),
    .pc_wr_i        (pc_wr_o),
    .pc_wr_cond_i   (pc_wr_cond_o),
    .mem_addr_sel_i (mem_addr_sel_o),
    .mem_rd_i       (mem_rd_o),
    .mem_wr_i       (mem_wr_o),
    .ir_load_i      (ir_load_o),
    .rf_data_sel_i  (rf_data_sel_o),
    .rf_wr_i        (rf_wr_o),
    .rf_dst_sel_i   (rf_dst_sel_o)
);

// File: tb/tb_mcc_ctrl.sv
`timescale 1ns/1ps
module tb_mcc_ctrl;
    localparam logic [5:0] C_ALU = 6'b000000;
    localparam logic [5:0] C_JMP = 6'b000010;
    localparam logic [5:0] C_BEQ = 6'b000100;
    localparam logic [5:0] C_LD  = 6'b100011;
    localparam logic [5:0] C_ST  = 6'b101011;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [5:0] op = 6'b0;
    logic pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_load, data_sel;
    logic [1:0] pc_src, alu_mode, b_sel;
    logic a_sel, rf_wr, dst_sel;

    int n_chk = 0;
    int n_fail = 0;
    int mst = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    mcc_ctrl dut (
        .clk_i(clk), .rst_i(rst), .op_i(op),
        .pc_wr_o(pc_wr), .pc_wr_cond_o(pc_wr_cond), .mem_addr_sel_o(addr_sel),
        .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .ir_load_o(ir_load),
        .rf_data_sel_o(data_sel), .pc_src_o(pc_src), .alu_mode_o(alu_mode),
        .alu_b_sel_o(b_sel), .alu_a_sel_o(a_sel), .rf_wr_o(rf_wr),
        .rf_dst_sel_o(dst_sel)
    );

    // vector: [15]pc_wr [14]pc_wr_cond [13]addr_sel [12]mem_rd [11]mem_wr
    // [10]ir_load [9]data_sel [8:7]pc_src [6:5]alu_mode [4:3]b_sel [2]a_sel [1]rf_wr [0]dst
    function automatic logic [15:0] exp_vec(int s);
        logic [15:0] v = '0;
        case (s)
            0: begin v[15] = 1; v[12] = 1; v[10] = 1; v[4:3] = 2'b01; end
            1: v[4:3] = 2'b11;
            2: begin v[2] = 1; v[4:3] = 2'b10; end
            3: begin v[12] = 1; v[13] = 1; end
            4: begin v[1] = 1; v[9] = 1; end
            5: begin v[11] = 1; v[13] = 1; end
            6: begin v[2] = 1; v[6:5] = 2'b10; end
            7: begin v[1] = 1; v[0] = 1; end
            8: begin v[2] = 1; v[6:5] = 2'b01; v[14] = 1; v[8:7] = 2'b01; end
            9: begin v[15] = 1; v[8:7] = 2'b10; end
            default: v = 'x;
        endcase
        return v;
    endfunction

    function automatic int nxt(int s, logic [5:0] o);
        if (s == 0) return 1;
        if (s == 1) begin
            if (o == C_LD || o == C_ST) return 2;
            if (o == C_ALU) return 6;
            if (o == C_BEQ) return 8;
            if (o == C_JMP) return 9;
            return 0;
        end
        if (s == 2) return (o == C_LD) ? 3 : (o == C_ST) ? 5 : 0;
        if (s == 3) return 4;
        if (s == 6) return 7;
        return 0;
    endfunction

    function automatic string st_tag(int s);
        string t [10] = '{"R2", "R3", "R5", "R6", "R6", "R7", "R8", "R8", "R9", "R10"};
        return t[s];
    endfunction

    task automatic step(logic [5:0] o, bit r, string tag);
        logic [15:0] act, ex;
        string t;
        @(negedge clk);
        act = {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_load, data_sel,
               pc_src, alu_mode, b_sel, a_sel, rf_wr, dst_sel};
        ex = exp_vec(mst);
        t = (tag == "") ? st_tag(mst) : tag;
        n_chk++;
        if (act !== ex) begin
            n_fail++;
            $display("FAIL %s step %0d outputs actual=%b expected=%b", t, mst, act, ex);
        end
        n_chk++;
        if ($countones({pc_wr, pc_wr_cond, mem_wr, rf_wr}) > 1) begin
            n_fail++;
            $display("FAIL R13 write strobes actual=%b expected at most one high",
                     {pc_wr, pc_wr_cond, mem_wr, rf_wr});
        end
        op = o;
        rst = r;
        mst = r ? 0 : nxt(mst, o);
    endtask

    task automatic run_instr(logic [5:0] o, logic [5:0] alt, bit use_alt, int exp_len, string tag);
        int cyc = 0;
        bit after_dec = 0;
        logic [5:0] cur;
        string t;
        do begin
            cur = (use_alt && mst >= 3) ? alt : o;
            t = after_dec ? "R4" : ((use_alt && mst >= 3) ? "R12" : "");
            after_dec = (mst == 1);
            step(cur, 1'b0, t);
            cyc++;
        end while (mst != 0 && cyc < 12);
        n_chk++;
        if (cyc != exp_len) begin
            n_fail++;
            $display("FAIL %s instruction length actual=%0d expected=%0d", tag, cyc, exp_len);
        end
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        mst = 0;
        step(C_LD, 1'b0, "R1");          // R1: fetch after reset
        mst = 1;
        // finish the load started by the R1 step
        run_instr(C_LD, C_LD, 1'b0, 4, "R6");
        run_instr(C_LD, C_LD, 1'b0, 5, "R6");
        run_instr(C_ST, C_ST, 1'b0, 4, "R7");
        run_instr(C_ALU, C_ALU, 1'b0, 4, "R8");
        run_instr(C_BEQ, C_BEQ, 1'b0, 3, "R9");
        run_instr(C_JMP, C_JMP, 1'b0, 3, "R10");
        run_instr(6'b111111, 6'b111111, 1'b0, 2, "R11");
        run_instr(6'b100010, 6'b100010, 1'b0, 2, "R11");
        run_instr(C_LD, C_ST, 1'b1, 5, "R12");
        run_instr(C_ALU, C_JMP, 1'b1, 4, "R12");
        run_instr(C_ST, C_LD, 1'b1, 4, "R12");
        run_instr(C_BEQ, C_LD, 1'b1, 3, "R12");
        // R5: stray opcode at the address step
        step(C_LD, 1'b0, "");
        step(C_LD, 1'b0, "");
        step(C_ALU, 1'b0, "R5");
        step(C_ALU, 1'b0, "R5");         // expects fetch again
        // R1: reset in the middle of a load
        step(C_LD, 1'b0, "");
        step(C_LD, 1'b0, "");
        step(C_LD, 1'b0, "");
        step(C_LD, 1'b1, "");
        step(C_LD, 1'b0, "R1");
        run_instr(C_ALU, C_ALU, 1'b0, 3, "R8");
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule